// File: doc/BRIEF.md
# Tri-State Phase-Frequency Detector with Lock Flag

This block compares two pulse trains inside a fast synchronous clock domain: a reference pulse and a pulse from the divided oscillator feedback. It decides which rising edge came first. It opens an error window on the first edge and closes it on the second. The result drives two charge-pump style outputs.

Each pump output is a drive level plus a drive enable. An enabled output pushes the loop filter one way or the other. A disabled output is released, which means high impedance. The two outputs use opposite polarity conventions, so that either an inverting (active) filter or a non-inverting (passive) filter can sit on the loop.

A lock flag falls for the cycles of each error window. Its low time therefore measures the phase error directly. Two edge-capture flags hold the state. When both flags are set, both are cleared together on the next clock.

Top module: `pfd_lock_top`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `act_en`=0, `pas_en`=0 and `lock_o`=1.
- R2: If a reference rising edge is captured at edge k and the next feedback rising edge at edge m>k, both enables are 1 after edges k+1 through m. During those cycles `act_lvl`=`ACT_UP_LVL` (default 0) and `pas_lvl` is its inverse. The enabled width equals m-k cycles.
- R3: If a feedback rising edge at edge k comes before a reference rising edge at edge m, both enables are 1 for m-k cycles. During those cycles `act_lvl` is the inverse of `ACT_UP_LVL` and `pas_lvl`=`ACT_UP_LVL`.
- R4: Reference and feedback rising edges captured at the same clock edge leave both outputs released (enables 0) and `lock_o` at 1.
- R5: `lock_o` is 0 exactly in the cycles where the pump outputs are enabled. Its low width equals the error width.
- R6: Further rising edges of the leading input, seen while an error window is open, are ignored. The window width is still measured from the first edge.
- R7: A rising edge that arrives in the clear cycle (the cycle after both flags became set) is kept. It opens a new error window.
- R8: An input held high produces only one edge. Holding it high does not open a new window after the window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse | input | 1 | Reference pulse, synchronous to clk |
| fb_pulse | input | 1 | Divided-oscillator feedback pulse, synchronous to clk |
| act_lvl | output | 1 | Drive level of the active-filter pump output |
| act_en | output | 1 | Drive enable of the active-filter pump output; 0 means released |
| pas_lvl | output | 1 | Drive level of the passive-filter pump output |
| pas_en | output | 1 | Drive enable of the passive-filter pump output; 0 means released |
| lock_o | output | 1 | Lock flag, low while a phase error is open |

## Verification
A wrong edge-capture flag shows at the pump pins one cycle after the edge that set it. It appears as an enable that comes on too early, stays on after the closing edge, or drives the wrong level. The bench's cycle model therefore catches it within two clocks. A lost or duplicated edge changes the measured window width, and the directed scenarios count that width exactly. A stuck clear path leaves one output enabled indefinitely, and the per-cycle comparison reports it at once.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    DIR_IDLE = 2'b00,
    DIR_UP   = 2'b01,
    DIR_DN   = 2'b10,
    DIR_BOTH = 2'b11
  } pump_dir_e;
endpackage

// File: rtl/pfd_edge.sv
module pfd_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= din;
  end

  // rising edge seen against the previous sample
  assign rise = din & ~prev_q;
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      up_set,
  input  logic      dn_set,
  output logic      up_q,
  output logic      dn_q,
  output pump_dir_e dir
);
  logic clr;

  // both captured: clear together one clock later
  assign clr = up_q & dn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      // an edge arriving in the clear cycle is still captured
      up_q <= (up_q & ~clr) | up_set;
      dn_q <= (dn_q & ~clr) | dn_set;
    end
  end

  assign dir = pump_dir_e'({dn_q, up_q});
endmodule

// File: rtl/pfd_drive.sv
module pfd_drive
  import pfd_pkg::*;
#(
  parameter bit UP_LVL = 1'b0
) (
  input  logic      clk,
  input  logic      rst,
  input  pump_dir_e dir,
  output logic      lvl,
  output logic      en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl <= 1'b0;
      en  <= 1'b0;
    end else begin
      en <= (dir == DIR_UP) || (dir == DIR_DN);
      if (dir == DIR_UP)      lvl <= UP_LVL;
      else if (dir == DIR_DN) lvl <= ~UP_LVL;
    end
  end
endmodule

// File: rtl/pfd_lockflag.sv
module pfd_lockflag
  import pfd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pump_dir_e dir,
  output logic      lock_o
);
  always_ff @(posedge clk) begin
    if (rst) lock_o <= 1'b1;
    else     lock_o <= !((dir == DIR_UP) || (dir == DIR_DN));
  end
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_pkg::*;
#(
  parameter bit ACT_UP_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_pulse,
  input  logic fb_pulse,
  output logic act_lvl,
  output logic act_en,
  output logic pas_lvl,
  output logic pas_en,
  output logic lock_o
);
  localparam int        NPUMP   = 2;
  localparam bit [1:0]  UP_LVLS = {~ACT_UP_LVL, ACT_UP_LVL};

  logic [1:0]       rise;
  logic             up_q;
  logic             dn_q;
  pump_dir_e        dir;
  logic [NPUMP-1:0] lvl_v;
  logic [NPUMP-1:0] en_v;

  pfd_edge #(.W(2)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .din  ({fb_pulse, ref_pulse}),
    .rise (rise)
  );

  pfd_core u_core (
    .clk    (clk),
    .rst    (rst),
    .up_set (rise[0]),
    .dn_set (rise[1]),
    .up_q   (up_q),
    .dn_q   (dn_q),
    .dir    (dir)
  );

  for (genvar g = 0; g < NPUMP; g++) begin : g_pump
    pfd_drive #(.UP_LVL(UP_LVLS[g])) u_drv (
      .clk (clk),
      .rst (rst),
      .dir (dir),
      .lvl (lvl_v[g]),
      .en  (en_v[g])
    );
  end

  pfd_lockflag u_lock (
    .clk    (clk),
    .rst    (rst),
    .dir    (dir),
    .lock_o (lock_o)
  );

  assign act_lvl = lvl_v[0];
  assign act_en  = en_v[0];
  assign pas_lvl = lvl_v[1];
  assign pas_en  = en_v[1];
endmodule

// File: rtl/pfd_lock_chk.sv
module pfd_lock_chk #(
  parameter bit ACT_UP_LVL = 1'b0
) (
  input logic clk,
  input logic rst,
  input logic ref_pulse,
  input logic fb_pulse,
  input logic act_lvl,
  input logic act_en,
  input logic pas_lvl,
  input logic pas_en,
  input logic lock_o,
  input logic up_q,
  input logic dn_q
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!act_en && !pas_en && lock_o));

  a_r2_ref_lead: assert property (@(posedge clk) disable iff (rst)
    (up_q && !dn_q) |=> (act_en && pas_en && act_lvl == ACT_UP_LVL && pas_lvl != ACT_UP_LVL));

  a_r3_fb_lead: assert property (@(posedge clk) disable iff (rst)
    (dn_q && !up_q) |=> (act_en && pas_en && act_lvl != ACT_UP_LVL && pas_lvl == ACT_UP_LVL));

  a_r4_release: assert property (@(posedge clk) disable iff (rst)
    (up_q == dn_q) |=> (!act_en && !pas_en));

  a_r5_lock_match: assert property (@(posedge clk) disable iff (rst)
    lock_o == !act_en);

  a_r7_clear_once: assert property (@(posedge clk) disable iff (rst)
    (up_q && dn_q && !ref_pulse && !fb_pulse) |=> (!up_q && !dn_q));
endmodule

bind pfd_lock_top pfd_lock_chk #(.ACT_UP_LVL(ACT_UP_LVL)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ref_pulse (ref_pulse),
  .fb_pulse  (fb_pulse),
  .act_lvl   (act_lvl),
  .act_en    (act_en),
  .pas_lvl   (pas_lvl),
  .pas_en    (pas_en),
  .lock_o    (lock_o),
  .up_q      (up_q),
  .dn_q      (dn_q)
);

// File: tb/test_pfd_lock_top.sv
module test_pfd_lock_top;
  localparam bit ACT_UP = 1'b0;
  localparam int S_IDLE = 0, S_REF = 1, S_FB = 2, S_CLR = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_pulse = 1'b0;
  logic fb_pulse = 1'b0;
  logic act_lvl, act_en, pas_lvl, pas_en, lock_o;

  int total = 0;
  int bad = 0;
  string cur_tag = "R1";
  bit armed = 1'b0;

  int ph = S_IDLE;
  bit pr = 1'b0, pf = 1'b0;
  bit e_en = 1'b0, e_act = 1'b0;
  int up_cnt = 0, dn_cnt = 0, lo_cnt = 0;

  always #10 clk = ~clk;

  pfd_lock_top #(.ACT_UP_LVL(ACT_UP)) i_pfd_lock_top (
    .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .act_lvl(act_lvl), .act_en(act_en), .pas_lvl(pas_lvl), .pas_en(pas_en),
    .lock_o(lock_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: who led, and which output state that implies next cycle
  always @(posedge clk) begin
    if (rst) begin
      ph = S_IDLE; pr = 1'b0; pf = 1'b0; e_en = 1'b0; e_act = 1'b0;
    end else begin
      bit re, fe;
      re = ref_pulse && !pr;
      fe = fb_pulse && !pf;
      pr = ref_pulse;
      pf = fb_pulse;
      e_en = (ph == S_REF) || (ph == S_FB);
      if (ph == S_REF) e_act = ACT_UP;
      else if (ph == S_FB) e_act = ~ACT_UP;
      if (ph == S_CLR) ph = S_IDLE;
      case (ph)
        S_IDLE: if (re && fe) ph = S_CLR; else if (re) ph = S_REF; else if (fe) ph = S_FB;
        S_REF:  if (fe) ph = S_CLR;
        S_FB:   if (re) ph = S_CLR;
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (armed && !rst) begin
      chk(act_en == e_en, {cur_tag, " act_en"}, act_en, e_en);
      chk(pas_en == e_en, {cur_tag, " pas_en"}, pas_en, e_en);
      chk(lock_o == !e_en, {cur_tag, " R5 lock_o"}, lock_o, !e_en);
      if (e_en) begin
        chk(act_lvl == e_act, {cur_tag, " act_lvl"}, act_lvl, e_act);
        chk(pas_lvl == !e_act, {cur_tag, " pas_lvl"}, pas_lvl, !e_act);
      end
      if (act_en && act_lvl == ACT_UP) up_cnt++;
      if (act_en && act_lvl != ACT_UP) dn_cnt++;
      if (!lock_o) lo_cnt++;
    end
  end

  task automatic step(input bit r, input bit f);
    @(negedge clk);
    ref_pulse = r;
    fb_pulse = f;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0);
  endtask

  task automatic zero_counts();
    @(negedge clk);
    up_cnt = 0; dn_cnt = 0; lo_cnt = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(act_en == 1'b0, "R1 act_en", act_en, 0);
    chk(pas_en == 1'b0, "R1 pas_en", pas_en, 0);
    chk(lock_o == 1'b1, "R1 lock_o", lock_o, 1);
    rst = 1'b0;
    armed = 1'b1;
    idle(3);

    // R2: reference leads by 3 clocks
    cur_tag = "R2"; zero_counts();
    step(1, 0); step(1, 0); step(1, 0); step(0, 1); idle(5);
    chk(up_cnt == 3, "R2 width", up_cnt, 3);
    chk(dn_cnt == 0, "R2 no opposite", dn_cnt, 0);
    chk(lo_cnt == 3, "R5 lock low width", lo_cnt, 3);

    // R3: feedback leads by 5 clocks
    cur_tag = "R3"; zero_counts();
    step(0, 1); idle(4); step(1, 0); idle(5);
    chk(dn_cnt == 5, "R3 width", dn_cnt, 5);
    chk(up_cnt == 0, "R3 no opposite", up_cnt, 0);

    // R4: aligned edges
    cur_tag = "R4"; zero_counts();
    step(1, 1); idle(5);
    chk(up_cnt + dn_cnt == 0, "R4 released", up_cnt + dn_cnt, 0);
    chk(lo_cnt == 0, "R4 lock stays high", lo_cnt, 0);

    // R6: second reference edge inside open window
    cur_tag = "R6"; zero_counts();
    step(1, 0); step(0, 0); step(1, 0); step(0, 0); step(0, 1); idle(5);
    chk(up_cnt == 4, "R6 width from first edge", up_cnt, 4);
    chk(dn_cnt == 0, "R6 no opposite", dn_cnt, 0);

    // R7: reference edge lands in the clear cycle
    cur_tag = "R7"; zero_counts();
    step(1, 0); step(0, 0); step(0, 1); step(1, 0); step(0, 0); step(0, 1); idle(6);
    chk(up_cnt == 4, "R7 both windows", up_cnt, 4);
    chk(dn_cnt == 0, "R7 no stray window", dn_cnt, 0);

    // R8: reference held high, no retrigger
    cur_tag = "R8"; zero_counts();
    step(1, 0); step(1, 0); step(1, 1);
    for (int i = 0; i < 8; i++) step(1, 0);
    chk(up_cnt == 2, "R8 single window", up_cnt, 2);
    chk(lock_o == 1'b1, "R8 lock high", lock_o, 1);
    idle(4);
    chk(up_cnt + dn_cnt == 2, "R8 after release", up_cnt + dn_cnt, 2);

    // R1: reset in the middle of a window
    cur_tag = "R1"; step(0, 1); step(0, 0);
    rst = 1'b1; armed = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(act_en == 1'b0 && pas_en == 1'b0, "R1 mid reset enables", act_en, 0);
    chk(lock_o == 1'b1, "R1 mid reset lock", lock_o, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule